// File: doc/BRIEF.md
# Sync Edge-Ratio Pulse Generator

This block sits in the fast converter clock domain behind an already-registered external synchronization input. It watches that input for rising edges and emits a single-cycle initialization pulse once every 1, 2, 4, 8 or 16 edges, as chosen by a 3-bit ratio code. The pulse is meant to re-seed a downstream 32-state clock generation machine. When the sync input runs faster than that machine's period, the ratio code thins the edges so that the surviving pulses stay spaced on a whole multiple of 32 fast-clock cycles.

Three ratio codes have no meaning. When one of them is applied, the block raises a flag and suppresses every pulse until a meaningful code returns. Writing any new code restarts the edge count, so the first pulse after a change always follows a full group of edges under the new code.

The control is a small state machine with three named states. ST_ARMED means the count is zero. ST_COUNT means some edges have been counted but the group is not complete. ST_BLOCKED means the code is invalid. The transitions are as follows. A group completes and the pulse fires: any valid state goes to ST_ARMED. An edge is counted short of the group: the machine goes to ST_COUNT. A code change with no edge: the machine goes to ST_ARMED. An invalid code is applied: any state goes to ST_BLOCKED. A valid code returns: ST_BLOCKED goes to ST_ARMED, or to ST_COUNT if an edge lands in the same cycle.

Top module: `sync_ratio_pulser`

## Requirements
- R1: `init_pulse_o` is high for exactly one clock cycle per pulse. It is registered, so it appears in the cycle after the clock edge at which the completing sync edge was sampled.
- R2: A rising edge is counted only when `sync_i` is sampled high at a clock edge after being sampled low at the previous edge. A level held high, or a falling edge, adds nothing.
- R3: Ratio code 0 (binary 000) pulses on every rising edge. It is the code the block assumes out of reset.
- R4: Ratio codes 1, 2, 3 and 4 need 2, 4, 8 and 16 rising edges per pulse. The pulse fires on the edge that completes the group, and the count then restarts from zero.
- R5: Ratio codes 5, 6 and 7 are invalid. While one is sampled, `ratio_bad_o` is high in the following cycle, no pulse is emitted, and the edge count is held at zero.
- R6: A ratio code that differs from the one sampled at the previous clock edge clears the edge count. A rising edge in that same cycle counts as the first edge under the new code.
- R7: With `sync_i` at one quarter of the clock rate, code 3 gives a pulse every 32 cycles and code 4 gives a pulse every 64 cycles.
- R8: While `rst_n` is low, both outputs are low. After release, counting begins from zero, with no edge history (a high `sync_i` at the first edge counts as a rise).
- R9: When a valid code follows an invalid one, `ratio_bad_o` drops one cycle later and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Sync input, already registered into this domain |
| ratio_i | input | CODE_W (3) | Ratio code: edges per pulse = 2^code for codes 0..4 |
| init_pulse_o | output | 1 | One-cycle initialization pulse |
| ratio_bad_o | output | 1 | High when the sampled ratio code is invalid |

## Verification
The edge that would complete a group can land in the same cycle as a write of a new ratio code. Under R6 the restart takes precedence, so that edge becomes the first of a new group and fires only when the new code is 0. A second collision is a completing edge in the cycle an invalid code appears, which must produce no pulse. Directed steps write the code in exactly the cycle of an edge, with the count one short of the old group. Random runs mix code writes with random sync activity, and a bench model built from the requirements predicts both outputs every cycle.

// File: rtl/sync_ratio_pkg.sv
package sync_ratio_pkg;

    // Control states of the edge-ratio pulser
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,   // count is zero, waiting for the first edge
        ST_COUNT   = 2'd1,   // part of an edge group collected
        ST_BLOCKED = 2'd2    // invalid ratio code, pulses suppressed
    } pulser_state_e;

endpackage

// File: rtl/sync_rise_detect.sv
module sync_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    // Previous sample; cleared by reset so a high level right after reset is a rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_i;
        end
    end

    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/sync_ratio_track.sv
module sync_ratio_track #(
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned MAX_CODE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   code_i,
    output logic                valid_o,
    output logic                changed_o,
    output logic [MAX_CODE:0]   target_o
);

    localparam int unsigned TGT_W = MAX_CODE + 1;

    logic [CODE_W-1:0] code_q;

    // Last sampled code; the reset value matches the default code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_i;
        end
    end

    assign changed_o = (code_i != code_q);
    assign valid_o   = (int'(code_i) <= int'(MAX_CODE));

    // Edges per pulse as a value: 2^code, one bit set per legal code
    always_comb begin
        target_o = '0;
        for (int unsigned i = 0; i < TGT_W; i++) begin
            if (int'(code_i) == int'(i)) begin
                target_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sync_ratio_fsm.sv
module sync_ratio_fsm
    import sync_ratio_pkg::*;
#(
    parameter int unsigned MAX_CODE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              valid_i,
    input  logic              changed_i,
    input  logic [MAX_CODE:0] target_i,
    output logic              pulse_o,
    output logic              invalid_o
);

    localparam int unsigned CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;
    localparam int unsigned TGT_W = MAX_CODE + 1;

    pulser_state_e     state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  base;
    logic [TGT_W-1:0]  incremented;
    logic              fire_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire_d  = 1'b0;
        base    = '0;
        unique case (state_q)
            ST_ARMED:   base = '0;
            ST_COUNT:   base = changed_i ? '0 : cnt_q;
            ST_BLOCKED: base = '0;
            default:    base = '0;
        endcase
        incremented = {{(TGT_W-CNT_W){1'b0}}, base} + TGT_W'(1);
        if (!valid_i) begin
            state_d = ST_BLOCKED;
            cnt_d   = '0;
        end else if (rise_i) begin
            if (incremented == target_i) begin
                fire_d  = 1'b1;
                cnt_d   = '0;
                state_d = ST_ARMED;
            end else begin
                cnt_d   = incremented[CNT_W-1:0];
                state_d = ST_COUNT;
            end
        end else begin
            cnt_d   = base;
            state_d = (base == '0) ? ST_ARMED : ST_COUNT;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_o   <= 1'b0;
            invalid_o <= 1'b0;
        end else begin
            pulse_o   <= fire_d;
            invalid_o <= ~valid_i;
        end
    end

endmodule

// File: rtl/sync_ratio_pulser.sv
module sync_ratio_pulser #(
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned MAX_CODE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [CODE_W-1:0] ratio_i,
    output logic              init_pulse_o,
    output logic              ratio_bad_o
);

    logic              rise;
    logic              code_ok;
    logic              code_new;
    logic [MAX_CODE:0] group_len;

    sync_rise_detect u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_i),
        .rise_o  (rise)
    );

    sync_ratio_track #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_i    (ratio_i),
        .valid_o   (code_ok),
        .changed_o (code_new),
        .target_o  (group_len)
    );

    sync_ratio_fsm #(
        .MAX_CODE (MAX_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .valid_i   (code_ok),
        .changed_i (code_new),
        .target_i  (group_len),
        .pulse_o   (init_pulse_o),
        .invalid_o (ratio_bad_o)
    );

endmodule

// File: rtl/sync_ratio_pulser_chk.sv
module sync_ratio_pulser_chk #(
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned MAX_CODE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_i,
    input logic [CODE_W-1:0] ratio_i,
    input logic              init_pulse_o,
    input logic              ratio_bad_o
);

    // Clock edges seen since reset release, saturating
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assert_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse_o |=> !init_pulse_o);

    assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && init_pulse_o) |-> ($past(sync_i) && !$past(sync_i, 2)));

    assert_every_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && $past(ratio_i) == '0 && $past(sync_i) && !$past(sync_i, 2))
        |-> init_pulse_o);

    assert_bad_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_bad_o |-> !init_pulse_o);

    assert_flag_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1) |-> (ratio_bad_o == (int'($past(ratio_i)) > int'(MAX_CODE))));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R8: assert (!init_pulse_o && !ratio_bad_o);
        end
    end

endmodule

bind sync_ratio_pulser sync_ratio_pulser_chk #(
    .CODE_W   (CODE_W),
    .MAX_CODE (MAX_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .ratio_i      (ratio_i),
    .init_pulse_o (init_pulse_o),
    .ratio_bad_o  (ratio_bad_o)
);

// File: tb/test_sync_ratio_pulser.sv
module test_sync_ratio_pulser;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_i = 1'b0;
    logic [2:0] ratio_i = 3'd0;
    logic       init_pulse_o;
    logic       ratio_bad_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic       m_prev = 1'b0;
    logic [2:0] m_code = 3'd0;
    int         m_cnt = 0;
    logic       exp_pulse = 1'b0;
    logic       exp_bad = 1'b0;
    string      last_tag = "R8";
    int         cyc = 0;
    int         last_p = -1;
    int         prev_p = -1;

    always #5 clk = ~clk;

    sync_ratio_pulser i_sync_ratio_pulser (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync_i),
        .ratio_i      (ratio_i),
        .init_pulse_o (init_pulse_o),
        .ratio_bad_o  (ratio_bad_o)
    );

    function automatic string tag_for(input logic [2:0] c, input bit chg);
        if (chg)     return "R6";
        if (c == 0)  return "R3";
        if (c > 4)   return "R5";
        return "R4";
    endfunction

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic model(input logic s, input logic [2:0] c);
        bit v, chg, e;
        int base;
        v = (c <= 3'd4);
        chg = (c != m_code);
        e = s && !m_prev;
        exp_pulse = 1'b0;
        if (!v) begin
            m_cnt = 0;
            exp_bad = 1'b1;
        end else begin
            exp_bad = 1'b0;
            base = chg ? 0 : m_cnt;
            if (e) begin
                if (base + 1 == (1 << c)) begin
                    exp_pulse = 1'b1;
                    m_cnt = 0;
                end else begin
                    m_cnt = base + 1;
                end
            end else begin
                m_cnt = base;
            end
        end
        m_prev = s;
        m_code = c;
    endtask

    // Check outputs of the previous step, then apply the next inputs
    task automatic drive(input logic s, input logic [2:0] c, input string tag);
        @(negedge clk);
        check(init_pulse_o, exp_pulse, last_tag, "pulse");
        check(ratio_bad_o, exp_bad, last_tag, "bad_flag");
        if (init_pulse_o) begin
            prev_p = last_p;
            last_p = cyc;
        end
        cyc++;
        sync_i = s;
        ratio_i = c;
        model(s, c);
        last_tag = (tag.len() != 0) ? tag : tag_for(c, 1'b0);
    endtask

    task automatic edges(input int n, input logic [2:0] c, input string tag);
        for (int k = 0; k < n; k++) begin
            drive(1'b1, c, tag);
            drive(1'b0, c, tag);
        end
    endtask

    task automatic period_run(input logic [2:0] c, input int cycles, input int gap);
        last_p = -1;
        prev_p = -1;
        for (int k = 0; k < cycles; k++) begin
            drive((k % 4) < 2, c, "R7");
        end
        checks++;
        if (last_p < 0 || prev_p < 0 || (last_p - prev_p) != gap) begin
            errors++;
            $display("FAIL R7 pulse spacing actual=%0d expected=%0d", last_p - prev_p, gap);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R8: outputs quiet during reset, even with sync high and a bad code
        sync_i = 1'b1;
        ratio_i = 3'd6;
        repeat (3) begin
            @(negedge clk);
            check(init_pulse_o, 1'b0, "R8", "pulse_in_reset");
            check(ratio_bad_o, 1'b0, "R8", "bad_in_reset");
        end
        sync_i = 1'b1;
        ratio_i = 3'd0;
        model(1'b1, 3'd0);    // first edge after release: prev cleared, counts as rise (R8)
        last_tag = "R8";
        @(negedge clk);
        rst_n = 1'b1;
        // Note: model already stepped for the first edge; wait it out through drive
        drive(1'b0, 3'd0, "R8");
        // R3: code 0, pulse per edge
        edges(4, 3'd0, "R3");
        // R2: level held high gives one pulse only; falling edge adds none
        drive(1'b1, 3'd0, "R2");
        for (int k = 0; k < 6; k++) drive(1'b1, 3'd0, "R2");
        drive(1'b0, 3'd0, "R2");
        drive(1'b0, 3'd0, "R2");
        // R4: each legal ratio over more than one group
        for (int c = 1; c <= 4; c++) begin
            drive(1'b0, 3'(c), "R6");
            edges(2 * (1 << c) + 1, 3'(c), "R4");
        end
        // R6: code change in the cycle of the would-be completing edge
        drive(1'b0, 3'd2, "R6");
        edges(3, 3'd2, "R6");
        drive(1'b1, 3'd1, "R6");   // new code: this edge is first of two
        drive(1'b0, 3'd1, "R6");
        edges(1, 3'd1, "R6");      // second edge fires
        edges(1, 3'd2, "R6");
        drive(1'b1, 3'd0, "R6");   // change to code 0 with an edge: fires at once
        drive(1'b0, 3'd0, "R6");
        // R5: invalid code with a completing edge in the same cycle
        drive(1'b0, 3'd1, "R6");
        edges(1, 3'd1, "R5");
        drive(1'b1, 3'd7, "R5");
        drive(1'b0, 3'd7, "R5");
        for (int c = 5; c <= 7; c++) edges(5, 3'(c), "R5");
        // R9: back to a valid code restarts from zero
        drive(1'b1, 3'd1, "R9");
        drive(1'b0, 3'd1, "R9");
        edges(3, 3'd1, "R9");
        // R7: quarter-rate sync
        period_run(3'd3, 200, 32);
        period_run(3'd4, 300, 64);
        // Random mix of edges and code writes
        begin
            logic       s;
            logic [2:0] c;
            s = 1'b0;
            c = 3'd0;
            for (int k = 0; k < 4000; k++) begin
                bit chg;
                chg = 1'b0;
                if ($urandom_range(0, 29) == 0) begin
                    logic [2:0] nc;
                    nc = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(5, 7))
                                                     : 3'($urandom_range(0, 4));
                    chg = (nc != c);
                    c = nc;
                end
                if ($urandom_range(0, 1) == 0) s = ~s;
                drive(s, c, tag_for(c, chg));
            end
        end
        drive(1'b0, 3'd0, "R3");
        drive(1'b0, 3'd0, "R3");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule